// File: doc/BRIEF.md
# Serial DAC Command Frame Assembler

This block sits behind a two-wire slave receiver that has already turned bus traffic into bytes. It sees a frame-start pulse, a frame-stop pulse and a byte with a valid strobe. From each frame it takes the leading address byte and compares it with the device's own 7-bit address and with a fixed broadcast byte. It then builds 24-bit command words. The first byte of a word is the command byte: bit 7 is reserved, bit 6 selects fast mode, bits 5:3 are the command code and bits 2:0 are the channel address. The next two bytes are the data word, high byte first. Each completed word produces one registered write: a command, a channel, 16 data bits and a strobe lasting one cycle.

In fast mode the command byte is held. Every later pair of data bytes in the same frame reissues that command with new data, so the command byte is not sent again. Lower-resolution variants set the parameter `DATA_BITS`. The code is left-justified and the unused low bits of the data output are forced to zero.

The controller has six states. `ST_IDLE` waits for a start. `ST_ADDR` expects the address byte. `ST_CMD` expects a command byte. `ST_DHI` and `ST_DLO` expect the data bytes. `ST_SKIP` swallows a frame that is not addressed to this device.

The transitions are as follows:
- A start moves any state to `ST_ADDR`.
- A stop moves any state to `ST_IDLE`, after any byte in the same cycle has been taken.
- In `ST_ADDR`, a matching byte moves to `ST_CMD` and any other byte moves to `ST_SKIP`.
- A byte in `ST_CMD` moves to `ST_DHI`.
- A byte in `ST_DHI` moves to `ST_DLO`.
- A byte in `ST_DLO` moves back to `ST_DHI` in fast mode and to `ST_CMD` otherwise.

Top module: `dac_cmd_framer`

## Requirements
- R1: While reset is asserted and directly after it, `wr_stb_o` and `rsv_err_o` are 0.
- R2: An address byte equal to `{own_addr_i, 1'b0}` or to 8'h10 opens the frame. Any other address byte makes the block ignore every byte until the next start. Bytes that arrive outside a frame are also ignored.
- R3: An address byte whose bit 0 is 1 (a read) is never accepted, not even `{own_addr_i,1'b1}` and not 8'h11.
- R4: When bit 6 of the command byte is 0, the command byte and two data bytes produce one strobe. The strobe comes in the cycle after the last byte. With it, `wr_cmd_o` = command[5:3], `wr_chan_o` = command[2:0] and `wr_data_o` = {first data byte, second data byte}. The next byte in the frame is taken as a new command byte. The strobe never lasts more than one cycle.
- R5: When bit 6 of the command byte is 1, each later pair of data bytes in the frame produces a further strobe with the stored command and channel.
- R6: A word whose command byte has bit 7 set produces no strobe and sets `rsv_err_o`. The flag stays set until reset.
- R7: A stop that arrives before the last byte of a word discards the partial word. No strobe follows, and later bytes are ignored until a start.
- R8: A stop in the same cycle as the last data byte still completes the word and gives its strobe.
- R9: A start in the middle of a frame abandons the partial word and clears the stored command. The next byte is taken as an address byte.
- R10: A byte that is valid in the same cycle as a start is discarded.
- R11: With `DATA_BITS` below 16, the low 16-`DATA_BITS` bits of `wr_data_o` are 0 on every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 7 | Device bus address |
| start_i | input | 1 | Frame start marker, one cycle |
| stop_i | input | 1 | Frame stop marker, one cycle |
| byte_vld_i | input | 1 | Byte valid strobe |
| byte_i | input | 8 | Received byte |
| wr_stb_o | output | 1 | Decoded write strobe, one cycle |
| wr_cmd_o | output | 3 | Command code |
| wr_chan_o | output | 3 | Channel address |
| wr_data_o | output | 16 | Data word, left-justified |
| rsv_err_o | output | 1 | Sticky reserved-bit error |

## Verification
Two events can fall in the same cycle. A byte can complete a word while a frame marker arrives: a stop together with the final data byte, or a start together with a byte. The bench drives the final data byte with the stop raised in the same cycle and expects exactly one strobe carrying that word. It also drives a start with a valid address byte and expects that byte to be dropped, so the byte sent next becomes the address. A second instance with 12 data bits is run alongside the first to judge the masking of the low data bits.

// File: rtl/dac_frm_pkg.sv
package dac_frm_pkg;
    localparam int ADDR_W     = 7;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 16;
    localparam int FIELD_W    = 3;
    localparam int RSV_BIT    = 7;
    localparam int SEL_BIT    = 6;
    localparam logic [BYTE_W-1:0] BCAST_BYTE = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DHI,
        ST_DLO,
        ST_SKIP
    } frm_state_e;
endpackage

// File: rtl/dac_frm_addr_match.sv
module dac_frm_addr_match
    import dac_frm_pkg::*;
(
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] addr_byte,
    output logic              hit
);
    // Only write transfers (R/W bit 0) are accepted, own or broadcast.
    always_comb begin
        hit = (addr_byte == {own_addr, 1'b0}) || (addr_byte == BCAST_BYTE);
    end
endmodule

// File: rtl/dac_frm_word_asm.sv
module dac_frm_word_asm
    import dac_frm_pkg::*;
#(
    parameter int DATA_BITS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_cmd,
    input  logic               ld_cmd,
    input  logic               ld_hi,
    input  logic               ld_lo,
    input  logic [BYTE_W-1:0]  byte_in,
    output logic [BYTE_W-1:0]  cmd_q,
    output logic               wr_stb,
    output logic [FIELD_W-1:0] wr_cmd,
    output logic [FIELD_W-1:0] wr_chan,
    output logic [WORD_W-1:0]  wr_data,
    output logic               rsv_err
);
    localparam int PAD = WORD_W - DATA_BITS;

    logic [BYTE_W-1:0] hi_q;
    logic [WORD_W-1:0] raw_word;
    logic [WORD_W-1:0] trim_word;

    assign raw_word = {hi_q, byte_in};

    generate
        if (PAD > 0) begin : g_trim
            assign trim_word = {raw_word[WORD_W-1:PAD], {PAD{1'b0}}};
        end else begin : g_full
            assign trim_word = raw_word;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            hi_q    <= '0;
            wr_stb  <= 1'b0;
            wr_cmd  <= '0;
            wr_chan <= '0;
            wr_data <= '0;
            rsv_err <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (clr_cmd) begin
                cmd_q <= '0;
                hi_q  <= '0;
            end else begin
                if (ld_cmd) cmd_q <= byte_in;
                if (ld_hi)  hi_q  <= byte_in;
                if (ld_lo) begin
                    if (cmd_q[RSV_BIT]) begin
                        rsv_err <= 1'b1;
                    end else begin
                        wr_stb  <= 1'b1;
                        wr_cmd  <= cmd_q[5:3];
                        wr_chan <= cmd_q[2:0];
                        wr_data <= trim_word;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dac_cmd_framer.sv
module dac_cmd_framer
    import dac_frm_pkg::*;
#(
    parameter int DATA_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   own_addr_i,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                byte_vld_i,
    input  logic [BYTE_W-1:0]   byte_i,
    output logic                wr_stb_o,
    output logic [FIELD_W-1:0]  wr_cmd_o,
    output logic [FIELD_W-1:0]  wr_chan_o,
    output logic [WORD_W-1:0]   wr_data_o,
    output logic                rsv_err_o
);
    frm_state_e state_q, state_d;
    logic addr_hit;
    logic ld_cmd, ld_hi, ld_lo;
    logic [BYTE_W-1:0] cmd_q;

    dac_frm_addr_match u_match (
        .own_addr  (own_addr_i),
        .addr_byte (byte_i),
        .hit       (addr_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and load controls
    always_comb begin
        state_d = state_q;
        ld_cmd  = 1'b0;
        ld_hi   = 1'b0;
        ld_lo   = 1'b0;
        if (start_i) begin
            state_d = ST_ADDR;
        end else begin
            if (byte_vld_i) begin
                unique case (state_q)
                    ST_ADDR: state_d = addr_hit ? ST_CMD : ST_SKIP;
                    ST_CMD: begin
                        ld_cmd  = 1'b1;
                        state_d = ST_DHI;
                    end
                    ST_DHI: begin
                        ld_hi   = 1'b1;
                        state_d = ST_DLO;
                    end
                    ST_DLO: begin
                        ld_lo   = 1'b1;
                        state_d = cmd_q[SEL_BIT] ? ST_DHI : ST_CMD;
                    end
                    ST_IDLE, ST_SKIP: state_d = state_q;
                endcase
            end
            if (stop_i) state_d = ST_IDLE;
        end
    end

    dac_frm_word_asm #(.DATA_BITS(DATA_BITS)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_cmd (start_i),
        .ld_cmd  (ld_cmd),
        .ld_hi   (ld_hi),
        .ld_lo   (ld_lo),
        .byte_in (byte_i),
        .cmd_q   (cmd_q),
        .wr_stb  (wr_stb_o),
        .wr_cmd  (wr_cmd_o),
        .wr_chan (wr_chan_o),
        .wr_data (wr_data_o),
        .rsv_err (rsv_err_o)
    );
endmodule

// File: rtl/dac_cmd_framer_chk.sv
module dac_cmd_framer_chk #(
    parameter int DATA_BITS = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        byte_vld_i,
    input logic        wr_stb_o,
    input logic [15:0] wr_data_o,
    input logic        rsv_err_o
);
    localparam int PAD = 16 - DATA_BITS;
    localparam logic [15:0] LOW_MASK = (16'(1) << PAD) - 16'd1;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_stb_o && !rsv_err_o));

    // R4
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R10
    stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(byte_vld_i && !start_i));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err_o |=> rsv_err_o);

    // R6
    err_nostb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsv_err_o) |-> !wr_stb_o);

    // R11
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ((wr_data_o & LOW_MASK) == 16'd0));
endmodule

bind dac_cmd_framer dac_cmd_framer_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .wr_stb_o   (wr_stb_o),
    .wr_data_o  (wr_data_o),
    .rsv_err_o  (rsv_err_o)
);

// File: tb/dac_cmd_framer_tb.sv
module dac_cmd_framer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] own_addr = 7'h0C;
    logic start_i = 0, stop_i = 0, byte_vld_i = 0;
    logic [7:0] byte_i = 0;
    logic wr_stb, wr_stb12, rsv_err, rsv_err12;
    logic [2:0] wr_cmd, wr_chan, wr_cmd12, wr_chan12;
    logic [15:0] wr_data, wr_data12;

    int total = 0, bad = 0;
    int n_stb = 0, n_stb12 = 0;
    logic [2:0] cap_cmd = 0, cap_chan = 0;
    logic [15:0] cap_data = 0, cap_data12 = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dac_cmd_framer u_dut (
        .clk(clk), .rst_n(rst_n), .own_addr_i(own_addr), .start_i(start_i),
        .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .wr_stb_o(wr_stb), .wr_cmd_o(wr_cmd), .wr_chan_o(wr_chan),
        .wr_data_o(wr_data), .rsv_err_o(rsv_err));

    dac_cmd_framer #(.DATA_BITS(12)) u_dut12 (
        .clk(clk), .rst_n(rst_n), .own_addr_i(own_addr), .start_i(start_i),
        .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .wr_stb_o(wr_stb12), .wr_cmd_o(wr_cmd12), .wr_chan_o(wr_chan12),
        .wr_data_o(wr_data12), .rsv_err_o(rsv_err12));

    always @(negedge clk) begin
        if (wr_stb) begin
            n_stb++;
            cap_cmd = wr_cmd; cap_chan = wr_chan; cap_data = wr_data;
        end
        if (wr_stb12) begin
            n_stb12++;
            cap_data12 = wr_data12;
        end
    end

    // {addr byte, command byte, data word, strobe expected}
    localparam logic [32:0] VEC [6] = '{
        {8'h18, 8'h1B, 16'hA5C3, 1'b1},
        {8'h10, 8'h08, 16'h1234, 1'b1},
        {8'h22, 8'h18, 16'hFFFF, 1'b0},
        {8'h19, 8'h18, 16'h0F0F, 1'b0},
        {8'h18, 8'h3F, 16'h0001, 1'b1},
        {8'h11, 8'h00, 16'h8000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic sp, input logic vld, input logic [7:0] b);
        @(negedge clk);
        start_i = st; stop_i = sp; byte_vld_i = vld; byte_i = b;
        @(negedge clk);
        start_i = 0; stop_i = 0; byte_vld_i = 0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        do_reset();
        settle();
        check("R1 stb", wr_stb, 0);
        check("R1 err", rsv_err, 0);

        // R2 R3 R4 R11 table
        for (int i = 0; i < 6; i++) begin
            base = n_stb;
            cyc(1, 0, 0, 0);
            cyc(0, 0, 1, VEC[i][32:25]);
            cyc(0, 0, 1, VEC[i][24:17]);
            cyc(0, 0, 1, VEC[i][16:9]);
            cyc(0, 0, 1, VEC[i][8:1]);
            cyc(0, 1, 0, 0);
            settle();
            check($sformatf("R2/R3 vec%0d count", i), n_stb - base, VEC[i][0] ? 1 : 0);
            if (VEC[i][0]) begin
                check("R4 cmd", cap_cmd, VEC[i][22:20]);
                check("R4 chan", cap_chan, VEC[i][19:17]);
                check("R4 data", cap_data, VEC[i][16:1]);
                check("R11 data12", cap_data12, VEC[i][16:1] & 16'hFFF0);
            end
        end
        check("R11 count12", n_stb12, n_stb);

        // R2: bytes outside a frame are ignored
        base = n_stb;
        cyc(0, 0, 1, 8'h18); cyc(0, 0, 1, 8'h08); cyc(0, 0, 1, 8'h11); cyc(0, 0, 1, 8'h22);
        settle();
        check("R2 outside frame", n_stb - base, 0);

        // R4: two standard words in one frame
        base = n_stb;
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h02); cyc(0, 0, 1, 8'h11); cyc(0, 0, 1, 8'h22);
        cyc(0, 0, 1, 8'h2D); cyc(0, 0, 1, 8'h33); cyc(0, 0, 1, 8'h44);
        cyc(0, 1, 0, 0); settle();
        check("R4 two words", n_stb - base, 2);
        check("R4 second cmd", cap_cmd, 3'd5);
        check("R4 second chan", cap_chan, 3'd5);
        check("R4 second data", cap_data, 16'h3344);

        // R5: fast mode, command 011 channel 001
        base = n_stb;
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h59); cyc(0, 0, 1, 8'hAB); cyc(0, 0, 1, 8'hCD);
        cyc(0, 0, 1, 8'h12); cyc(0, 0, 1, 8'h34);
        cyc(0, 0, 1, 8'h56); cyc(0, 0, 1, 8'h78);
        cyc(0, 1, 0, 0); settle();
        check("R5 pairs", n_stb - base, 3);
        check("R5 cmd", cap_cmd, 3'd3);
        check("R5 chan", cap_chan, 3'd1);
        check("R5 data", cap_data, 16'h5678);

        // R7: stop before the low byte
        base = n_stb;
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h08); cyc(0, 0, 1, 8'h99);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 1, 8'h77); cyc(0, 0, 1, 8'h66); cyc(0, 0, 1, 8'h55);
        settle();
        check("R7 partial dropped", n_stb - base, 0);

        // R8: stop with the final byte
        base = n_stb;
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h0A); cyc(0, 0, 1, 8'hBE);
        cyc(0, 1, 1, 8'hEF);
        cyc(0, 0, 1, 8'h01); cyc(0, 0, 1, 8'h02);
        settle();
        check("R8 count", n_stb - base, 1);
        check("R8 data", cap_data, 16'hBEEF);
        check("R8 chan", cap_chan, 3'd2);

        // R9: restart inside a fast-mode word
        base = n_stb;
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h5F); cyc(0, 0, 1, 8'hAA);
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h1A); cyc(0, 0, 1, 8'hC0); cyc(0, 0, 1, 8'hDE);
        cyc(0, 0, 1, 8'h20);
        cyc(0, 1, 0, 0); settle();
        check("R9 count", n_stb - base, 1);
        check("R9 cmd", cap_cmd, 3'd3);
        check("R9 chan", cap_chan, 3'd2);
        check("R9 data", cap_data, 16'hC0DE);

        // R10: byte alongside start is dropped
        base = n_stb;
        cyc(1, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h10);
        cyc(0, 0, 1, 8'h21); cyc(0, 0, 1, 8'h0F); cyc(0, 0, 1, 8'hF0);
        cyc(0, 1, 0, 0); settle();
        check("R10 count", n_stb - base, 1);
        check("R10 cmd", cap_cmd, 3'd4);
        check("R10 chan", cap_chan, 3'd1);
        check("R10 data", cap_data, 16'h0FF0);

        // R6: reserved bit set
        base = n_stb;
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h9A); cyc(0, 0, 1, 8'h11); cyc(0, 0, 1, 8'h22);
        cyc(0, 1, 0, 0); settle();
        check("R6 dropped", n_stb - base, 0);
        check("R6 err set", rsv_err, 1);
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h18);
        cyc(0, 0, 1, 8'h08); cyc(0, 0, 1, 8'h11); cyc(0, 0, 1, 8'h22);
        cyc(0, 1, 0, 0); settle();
        check("R6 next word ok", n_stb - base, 1);
        check("R6 err sticky", rsv_err, 1);
        do_reset(); settle();
        check("R6 err cleared by reset", rsv_err, 0);
        check("R1 stb after reset", wr_stb, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule